// File: doc/BRIEF.md
# Legacy Shadow Region Address Router

This block sits in a host bridge and decides, for every memory request, whether the request is served by main DRAM or passed down to the downstream I/O link. Each request carries an address, a read/write flag, the requester (processor, PCIe or downstream link), a snoop flag, and an indication that the snoop produced an implicit writeback. The decision is registered. The input and output both use a valid/ready handshake, and the decision appears one cycle after the request is accepted.

The legacy window from 768 KB to 1 MB is split into thirteen segments. Each segment has its own read-enable bit and its own write-enable bit, so reads and writes to the same segment can go to different targets. This is how firmware is copied into DRAM and then run from there. Above 1 MB, requests go to DRAM up to a programmable top-of-low-memory limit, except where they hit one of three enabled carve-out holes. A simple write-only register port programs the attribute bits, the limit and the holes.

Top module: `shadow_route_top`

## Requirements
- R1: The shadow window has twelve 16 KB segments from 0x0C0000 to 0x0EFFFF (segment i starts at 0x0C0000 + i*0x4000) and one 64 KB segment 12 from 0x0F0000 to 0x0FFFFF. Bit i of register 0 is segment i's read enable and bit i of register 1 is its write enable.
- R2: After reset every segment enable is 0, all holes are disabled, and any request to the shadow window is routed to the link (rsp_target 1; DRAM is rsp_target 0).
- R3: A read in the shadow window goes to DRAM when its segment's read enable is 1 and to the link otherwise. A write uses the write enable in the same way, independently of the read enable.
- R4: A request with req_snoop 0 whose source is PCIe (req_src 1) or the downstream link (req_src 2) is routed to DRAM anywhere in the shadow window, whatever the enables are. Processor requests (req_src 0) and snooped requests follow R3.
- R5: Addresses below 0x0C0000 always go to DRAM.
- R6: For addresses of 0x100000 and above, an address below the limit in register 2 goes to DRAM unless R7 applies, and an address at or above the limit goes to the link.
- R7: Register 3 bits [2:0] enable holes 0 to 2. Hole k has its base at register 4+2k and its byte size at register 5+2k, and it matches base <= addr < base+size. An address at 0x100000 or above that is below the limit and inside any enabled hole goes to the link, including when enabled holes overlap. A disabled hole has no effect.
- R8: rsp_error is 1 exactly when the request carried req_iwb 1 and was routed to the link.
- R9: An accepted request shows up on the output (rsp_valid 1, with its address and write flag) on the next cycle. The output holds steady while rsp_ready is 0, and req_ready is 1 whenever the output register is empty or is being drained.
- R10: A register write affects every request accepted after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register index |
| cfg_wdata | input | ADDR_W | Register write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_src | input | 2 | 0 processor, 1 PCIe, 2 downstream link |
| req_snoop | input | 1 | Request is snooped |
| req_iwb | input | 1 | Snoop returned an implicit writeback |
| rsp_valid | output | 1 | Routing decision present |
| rsp_ready | input | 1 | Decision consumed when high with rsp_valid |
| rsp_addr | output | ADDR_W | Address of the routed request |
| rsp_write | output | 1 | Write flag of the routed request |
| rsp_target | output | 1 | 0 DRAM, 1 downstream link |
| rsp_error | output | 1 | Illegal writeback toward the link |

## Verification
Reads and writes go to the same shadow addresses with the read and write enables set differently. This separates per-direction attribute handling from a shared enable and exposes segment-index errors at the 16 KB and 64 KB edges. The same shadow address is then sent with every source and snoop combination, which shows that only non-snooped PCIe and link traffic bypass the attributes. Addresses placed just below, at, and just past the limit and each hole edge, with overlapping and disabled holes, separate off-by-one compares from priority mistakes. A burst of requests under irregular output back-pressure checks ordering and hold behaviour against the scoreboard.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

   typedef enum logic [1:0] {
      SRC_CPU  = 2'd0,
      SRC_PCIE = 2'd1,
      SRC_LINK = 2'd2
   } req_src_e;

   typedef enum logic {
      TGT_DRAM = 1'b0,
      TGT_LINK = 1'b1
   } route_tgt_e;

   typedef struct packed {
      route_tgt_e tgt;
      logic       err;
   } route_dec_t;

   localparam int unsigned CFG_AW = 4;

   localparam logic [CFG_AW-1:0] CFG_RD_EN     = 4'd0;
   localparam logic [CFG_AW-1:0] CFG_WR_EN     = 4'd1;
   localparam logic [CFG_AW-1:0] CFG_TOP       = 4'd2;
   localparam logic [CFG_AW-1:0] CFG_HOLE_EN   = 4'd3;
   localparam logic [CFG_AW-1:0] CFG_HOLE_BASE = 4'd4;

endpackage

// File: rtl/shadow_route_regs.sv
module shadow_route_regs
   import shadow_route_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_SEG   = 13,
   parameter int unsigned NUM_HOLES = 3,
   parameter logic [ADDR_W-1:0] TOP_RST = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_we,
   input  logic [CFG_AW-1:0]        cfg_addr,
   input  logic [ADDR_W-1:0]        cfg_wdata,
   output logic [NUM_SEG-1:0]       rd_en_o,
   output logic [NUM_SEG-1:0]       wr_en_o,
   output logic [ADDR_W-1:0]        top_o,
   output logic [NUM_HOLES-1:0]     hole_en_o,
   output logic [NUM_HOLES-1:0][ADDR_W-1:0] hole_base_o,
   output logic [NUM_HOLES-1:0][ADDR_W-1:0] hole_size_o
);

   localparam int unsigned LAST_IDX = 32'(CFG_HOLE_BASE) + 2 * NUM_HOLES;

   generate
      if (NUM_SEG > ADDR_W) begin : g_bad_seg
         $error("segment count exceeds register width");
      end
      if (NUM_HOLES > ADDR_W) begin : g_bad_hen
         $error("hole count exceeds register width");
      end
      if (LAST_IDX > (1 << CFG_AW)) begin : g_bad_map
         $error("hole registers do not fit the register index");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_en_o   <= '0;
         wr_en_o   <= '0;
         top_o     <= TOP_RST;
         hole_en_o <= '0;
      end else if (cfg_we) begin
         case (cfg_addr)
            CFG_RD_EN:   rd_en_o   <= cfg_wdata[NUM_SEG-1:0];
            CFG_WR_EN:   wr_en_o   <= cfg_wdata[NUM_SEG-1:0];
            CFG_TOP:     top_o     <= cfg_wdata;
            CFG_HOLE_EN: hole_en_o <= cfg_wdata[NUM_HOLES-1:0];
            default: ;
         endcase
      end
   end

   for (genvar k = 0; k < NUM_HOLES; k++) begin : g_hole_reg
      localparam logic [CFG_AW-1:0] BASE_IDX = CFG_AW'(32'(CFG_HOLE_BASE) + 2 * k);
      localparam logic [CFG_AW-1:0] SIZE_IDX = CFG_AW'(32'(CFG_HOLE_BASE) + 2 * k + 1);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hole_base_o[k] <= '0;
            hole_size_o[k] <= '0;
         end else if (cfg_we) begin
            if (cfg_addr == BASE_IDX) hole_base_o[k] <= cfg_wdata;
            if (cfg_addr == SIZE_IDX) hole_size_o[k] <= cfg_wdata;
         end
      end
   end

endmodule

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned NUM_SMALL_SEG  = 12,
   parameter int unsigned SMALL_SEG_LOG2 = 14,
   parameter int unsigned LARGE_SEG_LOG2 = 16,
   parameter int unsigned SHADOW_BASE    = 32'h000C_0000
) (
   input  logic [ADDR_W-1:0]          addr_i,
   output logic                       in_shadow_o,
   output logic [NUM_SMALL_SEG:0]     seg_hit_o
);

   localparam int unsigned NUM_SEG    = NUM_SMALL_SEG + 1;
   localparam int unsigned LARGE_BASE = SHADOW_BASE + (NUM_SMALL_SEG << SMALL_SEG_LOG2);
   localparam int unsigned SHADOW_END = LARGE_BASE + (1 << LARGE_SEG_LOG2);

   generate
      if (SHADOW_END <= SHADOW_BASE) begin : g_bad_window
         $error("shadow window wraps");
      end
      if ((SHADOW_BASE % (1 << SMALL_SEG_LOG2)) != 0) begin : g_bad_align
         $error("shadow base not aligned to the small segment size");
      end
   endgenerate

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      localparam int unsigned LO = (i < NUM_SMALL_SEG) ?
                                   SHADOW_BASE + (i << SMALL_SEG_LOG2) : LARGE_BASE;
      localparam int unsigned HI = (i < NUM_SMALL_SEG) ?
                                   LO + (1 << SMALL_SEG_LOG2) : SHADOW_END;
      assign seg_hit_o[i] = (addr_i >= ADDR_W'(LO)) && (addr_i < ADDR_W'(HI));
   end

   assign in_shadow_o = |seg_hit_o;

endmodule

// File: rtl/shadow_hole_match.sv
module shadow_hole_match #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              en_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] size_i,
   output logic              hit_o
);

   logic [ADDR_W:0] lim_excl;
   logic            ge_base;
   logic            lt_lim;

   always_comb begin
      lim_excl = {1'b0, base_i} + {1'b0, size_i};
      ge_base  = addr_i >= base_i;
      lt_lim   = {1'b0, addr_i} < lim_excl;
      hit_o    = en_i && ge_base && lt_lim;
   end

endmodule

// File: rtl/shadow_route_top.sv
module shadow_route_top
   import shadow_route_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned NUM_SMALL_SEG  = 12,
   parameter int unsigned SMALL_SEG_LOG2 = 14,
   parameter int unsigned LARGE_SEG_LOG2 = 16,
   parameter int unsigned SHADOW_BASE    = 32'h000C_0000,
   parameter int unsigned NUM_HOLES      = 3,
   parameter int unsigned TOP_RST        = 32'h0010_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [1:0]        req_src,
   input  logic              req_snoop,
   input  logic              req_iwb,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_write,
   output logic              rsp_target,
   output logic              rsp_error
);

   localparam int unsigned NUM_SEG    = NUM_SMALL_SEG + 1;
   localparam int unsigned SHADOW_END = SHADOW_BASE + (NUM_SMALL_SEG << SMALL_SEG_LOG2)
                                        + (1 << LARGE_SEG_LOG2);

   generate
      if (ADDR_W < 21 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must cover the shadow window and fit 32 bits");
      end
      if (NUM_HOLES < 1) begin : g_bad_holes
         $error("at least one hole is required");
      end
   endgenerate

   logic [NUM_SEG-1:0]                rd_en, wr_en;
   logic [ADDR_W-1:0]                 top_lim;
   logic [NUM_HOLES-1:0]              hole_en;
   logic [NUM_HOLES-1:0][ADDR_W-1:0]  hole_base, hole_size;

   shadow_route_regs #(
      .ADDR_W    (ADDR_W),
      .NUM_SEG   (NUM_SEG),
      .NUM_HOLES (NUM_HOLES),
      .TOP_RST   (ADDR_W'(TOP_RST))
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_addr    (cfg_addr),
      .cfg_wdata   (cfg_wdata),
      .rd_en_o     (rd_en),
      .wr_en_o     (wr_en),
      .top_o       (top_lim),
      .hole_en_o   (hole_en),
      .hole_base_o (hole_base),
      .hole_size_o (hole_size)
   );

   logic               in_shadow;
   logic [NUM_SEG-1:0] seg_hit;

   shadow_seg_decode #(
      .ADDR_W         (ADDR_W),
      .NUM_SMALL_SEG  (NUM_SMALL_SEG),
      .SMALL_SEG_LOG2 (SMALL_SEG_LOG2),
      .LARGE_SEG_LOG2 (LARGE_SEG_LOG2),
      .SHADOW_BASE    (SHADOW_BASE)
   ) u_seg (
      .addr_i      (req_addr),
      .in_shadow_o (in_shadow),
      .seg_hit_o   (seg_hit)
   );

   logic [NUM_HOLES-1:0] hole_hit;

   for (genvar k = 0; k < NUM_HOLES; k++) begin : g_hole
      shadow_hole_match #(.ADDR_W(ADDR_W)) u_match (
         .addr_i (req_addr),
         .en_i   (hole_en[k]),
         .base_i (hole_base[k]),
         .size_i (hole_size[k]),
         .hit_o  (hole_hit[k])
      );
   end

   logic       below_win;
   logic       bypass;
   logic       attr_on;
   route_dec_t dec;

   always_comb begin
      below_win = req_addr < ADDR_W'(SHADOW_BASE);
      bypass    = !req_snoop &&
                  ((req_src == SRC_PCIE) || (req_src == SRC_LINK));
      attr_on   = req_write ? |(seg_hit & wr_en) : |(seg_hit & rd_en);

      if (below_win) begin
         dec.tgt = TGT_DRAM;
      end else if (in_shadow) begin
         dec.tgt = (bypass || attr_on) ? TGT_DRAM : TGT_LINK;
      end else if (req_addr >= top_lim) begin
         dec.tgt = TGT_LINK;
      end else if (|hole_hit) begin
         dec.tgt = TGT_LINK;
      end else begin
         dec.tgt = TGT_DRAM;
      end
      dec.err = (dec.tgt == TGT_LINK) && req_iwb;
   end

   logic              out_vld_q;
   logic [ADDR_W-1:0] out_addr_q;
   logic              out_wr_q;
   route_dec_t        out_dec_q;
   logic              take;

   assign req_ready = !out_vld_q || rsp_ready;
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld_q  <= 1'b0;
         out_addr_q <= '0;
         out_wr_q   <= 1'b0;
         out_dec_q  <= '{tgt: TGT_DRAM, err: 1'b0};
      end else begin
         if (take) begin
            out_vld_q  <= 1'b1;
            out_addr_q <= req_addr;
            out_wr_q   <= req_write;
            out_dec_q  <= dec;
         end else if (rsp_ready) begin
            out_vld_q  <= 1'b0;
         end
      end
   end

   assign rsp_valid  = out_vld_q;
   assign rsp_addr   = out_addr_q;
   assign rsp_write  = out_wr_q;
   assign rsp_target = out_dec_q.tgt;
   assign rsp_error  = out_dec_q.err;

   logic unused_end;
   assign unused_end = (SHADOW_END == 0);

endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SHADOW_BASE = 32'h000C_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_write,
   input logic              rsp_target,
   input logic              rsp_error
);

   // R5
   low_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_addr < ADDR_W'(SHADOW_BASE)) |-> !rsp_target);

   // R8
   err_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_error |-> (rsp_valid && rsp_target));

   // R9
   accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> rsp_valid);

   // R9
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) &&
         $stable(rsp_write) && $stable(rsp_target) && $stable(rsp_error)));

endmodule

bind shadow_route_top shadow_route_chk #(
   .ADDR_W      (ADDR_W),
   .SHADOW_BASE (SHADOW_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_ready  (rsp_ready),
   .rsp_addr   (rsp_addr),
   .rsp_write  (rsp_write),
   .rsp_target (rsp_target),
   .rsp_error  (rsp_error)
);

// File: tb/shadow_route_top_tb.sv
module shadow_route_top_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic          req_write = 1'b0;
   logic [1:0]    req_src = 2'd0;
   logic          req_snoop = 1'b1;
   logic          req_iwb = 1'b0;
   logic          rsp_valid;
   logic          rsp_ready = 1'b1;
   logic [AW-1:0] rsp_addr;
   logic          rsp_write;
   logic          rsp_target;
   logic          rsp_error;

   always #(CLK_PERIOD / 2) clk = ~clk;

   shadow_route_top u_dut (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_write (req_write), .req_src (req_src), .req_snoop (req_snoop),
      .req_iwb (req_iwb),
      .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_addr (rsp_addr),
      .rsp_write (rsp_write), .rsp_target (rsp_target), .rsp_error (rsp_error)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [AW-1:0] addr;
      logic          wr;
      logic          tgt;
      logic          err;
      string         tag;
   } exp_t;

   exp_t exp_q[$];

   // mirror of the programmed state
   logic [12:0]   m_rd = '0;
   logic [12:0]   m_wr = '0;
   logic [AW-1:0] m_top = 32'h0010_0000;
   logic [2:0]    m_hen = '0;
   logic [AW-1:0] m_hbase [3] = '{default: '0};
   logic [AW-1:0] m_hsize [3] = '{default: '0};

   function automatic logic model_tgt(logic [AW-1:0] a, logic w, logic [1:0] s, logic sn);
      int idx;
      logic en;
      if (a < 32'h000C_0000) return 1'b0;
      if (a < 32'h0010_0000) begin
         if (!sn && (s == 2'd1 || s == 2'd2)) return 1'b0;
         idx = (a < 32'h000F_0000) ? int'((a - 32'h000C_0000) / 32'h4000) : 12;
         en  = w ? m_wr[idx] : m_rd[idx];
         return !en;
      end
      if (a >= m_top) return 1'b1;
      for (int k = 0; k < 3; k++) begin
         if (m_hen[k] && a >= m_hbase[k] &&
             ({1'b0, a} < ({1'b0, m_hbase[k]} + {1'b0, m_hsize[k]})))
            return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(logic [3:0] idx, logic [AW-1:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = val;
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      case (idx)
         4'd0: m_rd  = val[12:0];
         4'd1: m_wr  = val[12:0];
         4'd2: m_top = val;
         4'd3: m_hen = val[2:0];
         4'd4: m_hbase[0] = val;
         4'd5: m_hsize[0] = val;
         4'd6: m_hbase[1] = val;
         4'd7: m_hsize[1] = val;
         4'd8: m_hbase[2] = val;
         4'd9: m_hsize[2] = val;
         default: ;
      endcase
   endtask

   task automatic send(string tag, logic [AW-1:0] a, logic w, logic [1:0] s,
                       logic sn, logic iwb);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = w;
      req_src = s; req_snoop = sn; req_iwb = iwb;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      e.addr = a; e.wr = w; e.tgt = model_tgt(a, w, s, sn);
      e.err  = e.tgt && iwb; e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk);
      #1;
      req_valid = 1'b0;
      // R9: result registered one cycle after acceptance
      check("R9 latency", 64'(rsp_valid), 64'd1);
   endtask

   // monitor: pops and compares on every output handshake
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected output", 64'(rsp_addr), 64'hFFFF_FFFF);
            end else begin
               e = exp_q.pop_front();
               check({e.tag, " addr"},   64'(rsp_addr),   64'(e.addr));
               check({e.tag, " write"},  64'(rsp_write),  64'(e.wr));
               check({e.tag, " target"}, 64'(rsp_target), 64'(e.tgt));
               check({e.tag, " error"},  64'(rsp_error),  64'(e.err));
            end
         end
      end
   end

   bit bp_on = 1'b0;
   int cyc   = 0;
   always @(negedge clk) begin
      cyc++;
      rsp_ready = bp_on ? ((cyc % 3) == 0 || (cyc % 7) == 1) : 1'b1;
   end

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R2 / R9: reset state of the handshake
      check("R2 reset rsp_valid", 64'(rsp_valid), 64'd0);
      check("R9 reset req_ready", 64'(req_ready), 64'd1);

      // R2: default attributes send shadow traffic to the link
      send("R2 read C0000",  32'h000C_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R2 write F8000", 32'h000F_8000, 1'b1, 2'd0, 1'b1, 1'b0);
      // R5
      send("R5 read 0",      32'h0000_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R5 write BFFFF", 32'h000B_FFFF, 1'b1, 2'd0, 1'b1, 1'b0);

      // R1 / R3: segment 3 readable, segment 12 writable, segment 11 readable
      cfg_write(4'd0, 32'h0000_0808);
      cfg_write(4'd1, 32'h0000_1000);
      send("R3 read seg3",    32'h000C_C010, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R3 write seg3",   32'h000C_C010, 1'b1, 2'd0, 1'b1, 1'b0);
      send("R3 write seg12",  32'h000F_0000, 1'b1, 2'd0, 1'b1, 1'b0);
      send("R3 read seg12",   32'h000F_FFFF, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R1 read seg2 top", 32'h000C_BFFF, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R1 read seg4",    32'h000D_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R1 read seg11 end", 32'h000E_FFFF, 1'b0, 2'd0, 1'b1, 1'b0);

      // R4: attribute bypass only for non-snooped PCIe and link traffic
      cfg_write(4'd0, 32'h0);
      cfg_write(4'd1, 32'h0);
      send("R4 nosnoop pcie read", 32'h000C_4000, 1'b0, 2'd1, 1'b0, 1'b0);
      send("R4 nosnoop link write", 32'h000F_4000, 1'b1, 2'd2, 1'b0, 1'b0);
      send("R4 nosnoop cpu read",  32'h000C_4000, 1'b0, 2'd0, 1'b0, 1'b0);
      send("R4 snoop pcie read",   32'h000C_4000, 1'b0, 2'd1, 1'b1, 1'b0);

      // R6: top-of-low-memory limit
      cfg_write(4'd2, 32'h0200_0000);
      send("R6 1MB",          32'h0010_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R6 below limit",  32'h01FF_FFFF, 1'b1, 2'd0, 1'b1, 1'b0);
      send("R6 at limit",     32'h0200_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R6 top address",  32'hFFFF_FFFF, 1'b0, 2'd1, 1'b1, 1'b0);

      // R7: holes
      cfg_write(4'd4, 32'h0150_0000);
      cfg_write(4'd5, 32'h0010_0000);
      cfg_write(4'd6, 32'h0180_0000);
      cfg_write(4'd7, 32'h0001_0000);
      cfg_write(4'd8, 32'h015F_0000);
      cfg_write(4'd9, 32'h0002_0000);
      cfg_write(4'd3, 32'h0000_0001);
      send("R7 below hole0",  32'h014F_FFFF, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R7 hole0 start",  32'h0150_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R7 hole0 end",    32'h015F_FFFF, 1'b1, 2'd0, 1'b1, 1'b0);
      send("R7 past hole0",   32'h0160_0000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R7 hole1 disabled", 32'h0180_8000, 1'b0, 2'd0, 1'b1, 1'b0);
      cfg_write(4'd3, 32'h0000_0005);
      send("R7 overlap",      32'h015F_8000, 1'b0, 2'd0, 1'b1, 1'b0);
      send("R7 hole2 tail",   32'h0160_8000, 1'b0, 2'd0, 1'b1, 1'b0);

      // R8: implicit writeback
      send("R8 iwb to link",  32'h000D_0000, 1'b0, 2'd0, 1'b1, 1'b1);
      send("R8 iwb to dram",  32'h0000_1000, 1'b0, 2'd0, 1'b1, 1'b1);

      // R10: register changes apply to later requests
      send("R10 before",      32'h000E_4000, 1'b0, 2'd0, 1'b1, 1'b0);
      cfg_write(4'd0, 32'h0000_0200);
      send("R10 after",       32'h000E_4000, 1'b0, 2'd0, 1'b1, 1'b0);

      // R9: burst under back-pressure
      bp_on = 1'b1;
      for (int i = 0; i < 40; i++) begin
         send("R9 burst", 32'h000C_0000 + 32'(i) * 32'h3000, 1'(i % 2),
              2'(i % 3), 1'((i / 3) % 2), 1'((i / 5) % 2));
      end
      bp_on = 1'b0;

      repeat (20) @(negedge clk);
      check("R9 queue drained", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      finish_run();
   end

endmodule